// File: doc/BRIEF.md
# Speaker Enable and Tone-Timer Status Port

This block is a byte-wide I/O register for the speaker path of a PC-style platform. A write to its port address stores two control bits. One is a speaker data-enable flag. The other is the gate of a tone timer. A read of the port returns those two bits together with the live level of the tone timer output. It also returns a refresh indicator that inverts on every read. Software polls this bit as a crude sign of progress.

The tone timer is included so the port can be exercised without the rest of the timer block. It is a square-wave down-counter with a reloadable divisor. While the gate is high, it inverts its output once every divisor count. While the gate is low, it freezes. The speaker drive output is the tone level qualified by the data-enable flag.

Read data is registered by default, so it appears one cycle after the read strobe. A parameter selects a combinational read path instead.

Top module: `spkr_port`

## Requirements
- R1: Only accesses whose address equals `PORT_ADDR` (default 0x61) reach the port. A write elsewhere leaves the enable and gate bits unchanged. A read elsewhere returns 0x00 and does not invert the refresh bit.
- R2: A port write stores `io_wdata[1]` as the speaker data-enable flag and `io_wdata[0]` as the timer gate. The other data bits are ignored. The new values take effect from the next cycle.
- R3: Port read data has the following layout, and every other bit is 0:
  - bit 0: gate
  - bit 1: data-enable
  - bit 4: refresh
  - bit 5: tone timer output

  With registered read data, this byte is on `io_rdata` in the cycle after the read strobe. `io_rdata` is 0x00 in every cycle that follows no port read.
- R4: The refresh bit inverts after each port read. The first read after reset returns it as 0.
- R5: When a port read and a port write fall in the same cycle, the read returns the state before the write.
- R6: A divisor load sets the reload value and restarts the count from it. The load does not change the output level, even when the gate is high.
- R7: While the gate is high, the tone output inverts once every max(N,1) cycles, where N is the loaded divisor. The first inversion comes N cycles after the gate is seen high.
- R8: While the gate is low, the tone counter and the tone output hold their values.
- R9: `spk_drive` is high exactly when the tone output and the data-enable flag are both high.
- R10: Reset clears the data-enable flag, the gate, the refresh bit and the tone output. It also loads the divisor with `DIV_RST` (default 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | ADDR_W | I/O address of the current access |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data (zero when no port read) |
| div_wr | input | 1 | Load strobe for the tone divisor |
| div_value | input | CNT_W | Tone divisor value |
| tone_out | output | 1 | Tone timer output level |
| spk_drive | output | 1 | Tone output qualified by data-enable |

## Verification
Register writes and divisor loads become visible in the cycle after their clock edge. A read byte lands on `io_rdata` in the same cycle and carries the pre-edge state. The tone output first inverts on the N-th edge after the gate edge and then every N edges. The bench drives all inputs on the falling edge and samples on the next falling edge. Each result is therefore compared exactly one edge after its stimulus. A bench-side model advances in step and is compared every cycle. Toggle counts over windows of whole divisor multiples are checked arithmetically for every divisor from 0 to 7.

// File: rtl/spkr_pkg.sv
`timescale 1ns/1ps
package spkr_pkg;
   // Read-byte bit positions; software decodes these.
   localparam int unsigned GATE_POS    = 0;
   localparam int unsigned DEN_POS     = 1;
   localparam int unsigned REFRESH_POS = 4;
   localparam int unsigned TONE_POS    = 5;
   localparam int unsigned BYTE_W      = 8;

   typedef struct packed {
      logic den;
      logic gate;
   } spkr_ctl_t;
endpackage

// File: rtl/spkr_ctl_reg.sv
`timescale 1ns/1ps
module spkr_ctl_reg
   import spkr_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned PORT_ADDR = 16'h0061
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              rd,
   input  logic [1:0]        wbits,
   output spkr_ctl_t         ctl,
   output logic              refresh,
   output logic              rd_hit
);
   localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(PORT_ADDR);

   logic hit;
   assign hit    = (addr == MATCH);
   assign rd_hit = rd & hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl     <= '0;
         refresh <= 1'b0;
      end else begin
         if (wr && hit) begin
            ctl.den  <= wbits[DEN_POS];
            ctl.gate <= wbits[GATE_POS];
         end
         if (rd_hit) begin
            refresh <= ~refresh;
         end
      end
   end
endmodule

// File: rtl/spkr_tone_cnt.sv
`timescale 1ns/1ps
module spkr_tone_cnt #(
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned DIV_RST = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             gate,
   input  logic             div_wr,
   input  logic [CNT_W-1:0] div_value,
   output logic             tone
);
   localparam logic [CNT_W-1:0] RST_VAL = CNT_W'(DIV_RST);
   localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

   logic [CNT_W-1:0] div_q;
   logic [CNT_W-1:0] cnt_q;
   logic             wrap;

   // Terminal count: a count of 1 (or a zero divisor) wraps this cycle.
   assign wrap = (cnt_q <= ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= RST_VAL;
         cnt_q <= RST_VAL;
         tone  <= 1'b0;
      end else if (div_wr) begin
         div_q <= div_value;
         cnt_q <= div_value;
      end else if (gate) begin
         if (wrap) begin
            cnt_q <= div_q;
            tone  <= ~tone;
         end else begin
            cnt_q <= cnt_q - ONE;
         end
      end
   end
endmodule

// File: rtl/spkr_rdata.sv
`timescale 1ns/1ps
module spkr_rdata
   import spkr_pkg::*;
#(
   parameter bit RDATA_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_hit,
   input  spkr_ctl_t         ctl,
   input  logic              refresh,
   input  logic              tone,
   output logic [BYTE_W-1:0] rdata
);
   logic [BYTE_W-1:0] byte_v;

   always_comb begin
      byte_v              = '0;
      byte_v[GATE_POS]    = ctl.gate;
      byte_v[DEN_POS]     = ctl.den;
      byte_v[REFRESH_POS] = refresh;
      byte_v[TONE_POS]    = tone;
   end

   if (RDATA_REG) begin : g_reg
      logic [BYTE_W-1:0] rdata_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rdata_q <= '0;
         else        rdata_q <= rd_hit ? byte_v : '0;
      end
      assign rdata = rdata_q;
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign rdata = rd_hit ? byte_v : '0;
   end
endmodule

// File: rtl/spkr_port.sv
`timescale 1ns/1ps
module spkr_port
   import spkr_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned PORT_ADDR = 16'h0061,
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned DIV_RST   = 4,
   parameter bit          RDATA_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [7:0]        io_wdata,
   output logic [7:0]        io_rdata,
   input  logic              div_wr,
   input  logic [CNT_W-1:0]  div_value,
   output logic              tone_out,
   output logic              spk_drive
);
   if (CNT_W < 2) begin : g_bad_cnt
      $error("spkr_port: CNT_W must be at least 2");
   end
   if (ADDR_W < 32 && PORT_ADDR >= (64'd1 << ADDR_W)) begin : g_bad_addr
      $error("spkr_port: PORT_ADDR does not fit in ADDR_W");
   end
   if (DIV_RST >= (64'd1 << CNT_W)) begin : g_bad_div
      $error("spkr_port: DIV_RST does not fit in CNT_W");
   end

   spkr_ctl_t ctl_q;
   logic      refresh_q;
   logic      rd_hit;
   logic      den_w;
   logic      gate_w;
   logic      unused_wbits;

   assign unused_wbits = ^io_wdata[7:2];
   assign den_w        = ctl_q.den;
   assign gate_w       = ctl_q.gate;

   spkr_ctl_reg #(
      .ADDR_W   (ADDR_W),
      .PORT_ADDR(PORT_ADDR)
   ) ctl_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .addr   (io_addr),
      .wr     (io_wr),
      .rd     (io_rd),
      .wbits  (io_wdata[1:0]),
      .ctl    (ctl_q),
      .refresh(refresh_q),
      .rd_hit (rd_hit)
   );

   spkr_tone_cnt #(
      .CNT_W  (CNT_W),
      .DIV_RST(DIV_RST)
   ) cnt_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .gate     (gate_w),
      .div_wr   (div_wr),
      .div_value(div_value),
      .tone     (tone_out)
   );

   spkr_rdata #(
      .RDATA_REG(RDATA_REG)
   ) rd_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_hit (rd_hit),
      .ctl    (ctl_q),
      .refresh(refresh_q),
      .tone   (tone_out),
      .rdata  (io_rdata)
   );

   assign spk_drive = tone_out & den_w;
endmodule

// File: rtl/spkr_port_chk.sv
`timescale 1ns/1ps
module spkr_port_chk #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned PORT_ADDR = 16'h0061,
   parameter bit          RDATA_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] io_addr,
   input logic              io_wr,
   input logic              io_rd,
   input logic [7:0]        io_wdata,
   input logic [7:0]        io_rdata,
   input logic              tone_out,
   input logic              den,
   input logic              gate,
   input logic              refresh
);
   logic hit;
   assign hit = (io_addr == ADDR_W'(PORT_ADDR));

   p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && hit) |=> (den == $past(io_wdata[1]) && gate == $past(io_wdata[0])));

   p_foreign_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> ($stable(den) && $stable(gate) && $stable(refresh)));

   p_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && hit) |=> (refresh != $past(refresh)));

   p_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_rd && hit) |=> $stable(refresh));

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !gate |=> $stable(tone_out));

   if (RDATA_REG) begin : g_rd_chk
      p_idle_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
         !(io_rd && hit) |=> (io_rdata == 8'h00));

      p_pad_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (io_rd && hit) |=> (io_rdata[7:6] == 2'b00 && io_rdata[3:2] == 2'b00));
   end
endmodule

bind spkr_port spkr_port_chk #(
   .ADDR_W   (ADDR_W),
   .PORT_ADDR(PORT_ADDR),
   .RDATA_REG(RDATA_REG)
) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .io_addr (io_addr),
   .io_wr   (io_wr),
   .io_rd   (io_rd),
   .io_wdata(io_wdata),
   .io_rdata(io_rdata),
   .tone_out(tone_out),
   .den     (den_w),
   .gate    (gate_w),
   .refresh (refresh_q)
);

// File: tb/spkr_port_tb_top.sv
`timescale 1ns/1ps
module spkr_port_tb_top;
   localparam int unsigned AW    = 16;
   localparam int unsigned CW    = 16;
   localparam logic [15:0] PORT  = 16'h0061;
   localparam int unsigned DRST  = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] io_addr = '0;
   logic          io_wr = 1'b0;
   logic          io_rd = 1'b0;
   logic [7:0]    io_wdata = '0;
   logic [7:0]    io_rdata;
   logic          div_wr = 1'b0;
   logic [CW-1:0] div_value = '0;
   logic          tone_out;
   logic          spk_drive;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   spkr_port dut_i (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
      .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
      .div_wr(div_wr), .div_value(div_value),
      .tone_out(tone_out), .spk_drive(spk_drive)
   );

   // Behavioural expectation built from the requirements.
   logic          m_den, m_gate, m_ref, m_out;
   logic [CW-1:0] m_cnt, m_div;
   logic [7:0]    m_rd;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_den <= 0; m_gate <= 0; m_ref <= 0; m_out <= 0;
         m_cnt <= CW'(DRST); m_div <= CW'(DRST); m_rd <= 8'h00;
      end else begin
         m_rd <= (io_rd && io_addr == PORT) ?
                 {2'b00, m_out, m_ref, 2'b00, m_den, m_gate} : 8'h00;
         if (io_rd && io_addr == PORT) m_ref <= ~m_ref;
         if (io_wr && io_addr == PORT) begin
            m_den <= io_wdata[1]; m_gate <= io_wdata[0];
         end
         if (div_wr) begin
            m_div <= div_value; m_cnt <= div_value;
         end else if (m_gate) begin
            if (m_cnt <= 1) begin m_cnt <= m_div; m_out <= ~m_out; end
            else m_cnt <= m_cnt - 1;
         end
      end
   end

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, exp, $time);
      end
   endtask

   // Every-cycle comparison against the expectation.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R3 rdata", {24'd0, io_rdata}, {24'd0, m_rd});
         check("R7 tone", {31'd0, tone_out}, {31'd0, m_out});
         check("R9 spk_drive", {31'd0, spk_drive}, {31'd0, m_out & m_den});
      end
   end

   task automatic tick();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic port_wr(logic [AW-1:0] a, logic [7:0] d);
      io_addr = a; io_wdata = d; io_wr = 1'b1; tick(); io_wr = 1'b0;
   endtask

   task automatic port_rd(logic [AW-1:0] a, output logic [7:0] d);
      io_addr = a; io_rd = 1'b1; tick(); io_rd = 1'b0; d = io_rdata;
   endtask

   task automatic load_div(logic [CW-1:0] v);
      div_value = v; div_wr = 1'b1; tick(); div_wr = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0; tick(); tick(); rst_n = 1'b1;
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         done = 1'b1;
         summary();
         $finish;
      end
   end

   initial begin : stim
      logic [7:0] d, d2;
      logic       t0;
      int         flips;
      do_reset();
      // R10: reset state at the ports
      check("R10 rdata after reset", {24'd0, io_rdata}, 32'h00);
      check("R10 tone after reset", {31'd0, tone_out}, 32'h0);
      port_rd(PORT, d);
      check("R10 R4 first read", {24'd0, d}, 32'h00);
      port_rd(PORT, d);
      check("R4 second read refresh", {31'd0, d[4]}, 32'h1);

      // R2/R3: sweep every write byte, each followed by a read
      for (int v = 0; v < 256; v++) begin
         port_wr(PORT, 8'(v));
         port_rd(PORT, d);
         check("R2 stored bits", {30'd0, d[1:0]}, {30'd0, 2'(v & 3)});
         check("R3 padding bits", {24'd0, d & 8'hCC}, 32'h00);
      end

      // R1: foreign addresses leave the port alone
      port_wr(PORT, 8'h00);
      port_rd(PORT, d);
      for (int a = 0; a < 8; a++) begin
         logic [AW-1:0] fa;
         fa = PORT ^ AW'(16'h1 << (a * 2));
         port_wr(fa, 8'hFF);
         port_rd(fa, d2);
         check("R1 foreign read zero", {24'd0, d2}, 32'h00);
      end
      port_rd(PORT, d2);
      check("R1 bits kept", {30'd0, d2[1:0]}, 32'h0);
      check("R1 refresh not flipped", {31'd0, d2[4]}, {31'd0, ~d[4]});

      // R5: simultaneous read and write returns pre-write state
      io_addr = PORT; io_wdata = 8'h03; io_wr = 1'b1; io_rd = 1'b1;
      tick(); io_wr = 1'b0; io_rd = 1'b0;
      check("R5 pre-write state", {30'd0, io_rdata[1:0]}, 32'h0);
      port_rd(PORT, d);
      check("R5 write landed", {30'd0, d[1:0]}, 32'h3);

      // R7/R8: divisor sweep with arithmetic toggle counts
      for (int n = 0; n < 8; n++) begin
         int per;
         per = (n == 0) ? 1 : n;
         port_wr(PORT, 8'h02);
         load_div(CW'(n));
         port_wr(PORT, 8'h03);
         flips = 0; t0 = tone_out;
         for (int c = 0; c < 4 * per; c++) begin
            tick();
            if (tone_out != t0) begin flips++; t0 = tone_out; end
            if (c == per - 2) check("R7 no early toggle", {31'd0, 1'(flips)}, 32'h0);
         end
         check("R7 toggles in 4 periods", flips, 4);
         port_wr(PORT, 8'h02);
         t0 = tone_out;
         repeat (10) tick();
         check("R8 hold with gate low", {31'd0, tone_out}, {31'd0, t0});
         check("R9 drive with enable", {31'd0, spk_drive}, {31'd0, t0});
      end

      // R6: divisor load mid-run restarts the count
      load_div(CW'(5));
      port_wr(PORT, 8'h03);
      repeat (3) tick();
      t0 = tone_out;
      load_div(CW'(3));
      check("R6 load keeps level", {31'd0, tone_out}, {31'd0, t0});
      repeat (2) tick();
      check("R6 not yet", {31'd0, tone_out}, {31'd0, t0});
      tick();
      check("R6 toggle after new divisor", {31'd0, tone_out}, {31'd0, ~t0});
      port_wr(PORT, 8'h01);
      check("R9 drive without enable", {31'd0, spk_drive}, 32'h0);

      // R10: reset mid-run, then default divisor governs
      do_reset();
      check("R10 tone cleared", {31'd0, tone_out}, 32'h0);
      port_rd(PORT, d);
      check("R10 state cleared", {24'd0, d}, 32'h00);
      port_wr(PORT, 8'h01);
      repeat (DRST - 1) tick();
      check("R10 default divisor not yet", {31'd0, tone_out}, 32'h0);
      tick();
      check("R10 default divisor toggle", {31'd0, tone_out}, 32'h1);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule